// File: doc/BRIEF.md
# Six-Bit General-Purpose Port with Direction Control and Change Interrupt

This block is the register and pin logic of a small parallel I/O port. A bus master writes an output latch and a direction register through strobes, and reads back the port. The read returns the synchronized levels seen at the pins, not the latch. Each pin is driven from its latch bit when its direction bit is 0 and left floating when the bit is 1. One bit position is input-only: it has no latch and no driver, and its direction bit is hardwired to 1. That bit can also be configured as the chip's reset input. In that mode it reads as 0, its pull-up is forced on, and it can raise no change interrupt.

A fixed group of three pins (bits 0, 1 and 3) shares one pull-up enable and one change detector. The detector compares the synchronized pins of that group against a snapshot taken at the most recent port read. Any difference sets a sticky flag, whatever the state of the enable. The interrupt request is that flag gated by the enable. A single-bit read-modify-write operation models a bit set or bit clear by the processor: the current read view of the whole port, with that one bit replaced, is written back into the latch. Alternate-function masks only force the affected read bits to 0.

Top module: `gpio_port_block`

## Requirements
- R1: After a synchronous reset every direction bit reads 1, `pin_oe` is 0, the output latch (`pin_out`) is 0 and `chg_flag` is 0.
- R2: `port_rdata` carries the pin levels after a two-flop synchronizer and one output register, three clock edges after a pin change. It never reflects the latch.
- R3: Bit 3 is input-only: `pin_out[3]` and `pin_oe[3]` are always 0 and `dir_rdata[3]` is always 1, whatever value is written.
- R4: Any bit set in `cfg_alt_mask` reads as 0 in `port_rdata`.
- R5: With `cfg_rst_pin` = 1, bit 3 reads 0, `pin_pullup[3]` is 1, and a change on pin 3 does not set `chg_flag`.
- R6: A read-modify-write (`rmw_en`) loads the latch with the current port read view, with bit `rmw_bit` replaced by `rmw_val`. This includes input bits and output bits whose pins read differently. `port_wr` takes precedence.
- R7: With `cfg_pullup_en` = 1, `pin_pullup` is 6'b001011. The pull-ups on bits 0, 1 and 3 switch together and no other bit ever gets one.
- R8: A difference between the synchronized pins 0, 1 or 3 and the snapshot taken at the last `port_rd` sets `chg_flag` on the next edge, regardless of `chg_en`. Changes on bits 2, 4 and 5 never set it.
- R9: `chg_flag` stays set until `chg_clr`. If a new change is seen in the same cycle as `chg_clr`, the flag stays set.
- R10: `chg_irq` is `chg_flag` AND `chg_en`.
- R11: A direction bit of 0 drives that pin (`pin_oe` = 1) with its latch value; a 1 tri-states it. `dir_wr` loads the direction register from `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata | input | 6 | Write data for latch and direction register |
| port_wr | input | 1 | Latch write strobe |
| port_rd | input | 1 | Port read strobe; takes the change snapshot |
| dir_wr | input | 1 | Direction register write strobe |
| rmw_en | input | 1 | Single-bit read-modify-write strobe |
| rmw_bit | input | 3 | Bit index for read-modify-write |
| rmw_val | input | 1 | New value for the selected bit |
| cfg_rst_pin | input | 1 | Bit 3 acts as reset input |
| cfg_pullup_en | input | 1 | Common pull-up enable for bits 0, 1, 3 |
| cfg_alt_mask | input | 6 | Bits used by alternate functions (read as 0) |
| chg_en | input | 1 | Change interrupt enable |
| chg_clr | input | 1 | Clear the change flag |
| pin_in | input | 6 | Raw pin levels |
| pin_out | output | 6 | Output data to pins |
| pin_oe | output | 6 | Output enables, 1 = drive |
| pin_pullup | output | 6 | Weak pull-up enables |
| port_rdata | output | 6 | Registered port read view |
| dir_rdata | output | 6 | Direction register read view |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Change interrupt request |

## Verification
A software clear of the change flag and a fresh pin change can meet on the same edge. The bench provokes this by toggling pin 0 and then holding `chg_clr` across the exact edge on which the synchronized value first differs from the snapshot. It then requires the flag to still be 1, and to reach 0 only after a port read and a later clear. A second overlap is a latch write and a read-modify-write in one cycle; there the write wins. The bench also shows that a read-modify-write copies pin levels, not latch contents, into output bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // One-hot mask of a single bit position within a port of width w
  function automatic logic [31:0] bit_mask(input int pos);
    return 32'(1) << pos;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W        = 6,
  parameter int SOLO_BIT = 3,
  parameter int IDXW     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    wdata,
  input  logic            port_wr,
  input  logic            dir_wr,
  input  logic            rmw_en,
  input  logic [IDXW-1:0] rmw_bit,
  input  logic            rmw_val,
  input  logic [W-1:0]    read_view,
  output logic [W-1:0]    latch_q,
  output logic [W-1:0]    dir_q
);
  import gpio_pkg::*;
  localparam logic [W-1:0] SOLO = W'(bit_mask(SOLO_BIT));

  logic [W-1:0] rmw_word;

  always_comb begin
    for (int i = 0; i < W; i++)
      rmw_word[i] = (int'(rmw_bit) == i) ? rmw_val : read_view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else begin
      if (port_wr)     latch_q <= wdata & ~SOLO;
      else if (rmw_en) latch_q <= rmw_word & ~SOLO;
      if (dir_wr)      dir_q   <= wdata | SOLO;
    end
  end

  assert_latch_write_R6: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> latch_q == ($past(wdata) & ~SOLO));

  assert_rmw_sets_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (rmw_en && !port_wr && int'(rmw_bit) < W && int'(rmw_bit) != SOLO_BIT)
      |=> latch_q[$past(rmw_bit)] == $past(rmw_val));

  assert_dir_write_R11: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> (dir_q & ~SOLO) == ($past(wdata) & ~SOLO));
endmodule

// File: rtl/gpio_chg.sv
module gpio_chg #(
  parameter int           W        = 6,
  parameter int           SOLO_BIT = 3,
  parameter logic [W-1:0] WATCH    = 6'b001011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_sync,
  input  logic         port_rd,
  input  logic         solo_is_rst,
  input  logic         chg_clr,
  output logic         flag_q
);
  import gpio_pkg::*;
  localparam logic [W-1:0] SOLO = W'(bit_mask(SOLO_BIT));

  logic [W-1:0] snap_q;
  logic [W-1:0] watch_now;
  logic         mismatch;

  assign watch_now = WATCH & ~(solo_is_rst ? SOLO : '0);
  assign mismatch  = |((pins_sync ^ snap_q) & watch_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (port_rd) snap_q <= pins_sync;
      flag_q <= (flag_q & ~chg_clr) | mismatch;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !chg_clr) |=> flag_q);

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(mismatch));
endmodule

// File: rtl/gpio_port_block.sv
module gpio_port_block #(
  parameter int               P_WIDTH    = 6,
  parameter int               P_SOLO_BIT = 3,
  parameter int               P_SYNC     = 2,
  parameter logic [P_WIDTH-1:0] P_CHG_MASK = 6'b001011,
  localparam int              IDXW       = $clog2(P_WIDTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [P_WIDTH-1:0] wdata,
  input  logic               port_wr,
  input  logic               port_rd,
  input  logic               dir_wr,
  input  logic               rmw_en,
  input  logic [IDXW-1:0]    rmw_bit,
  input  logic               rmw_val,
  input  logic               cfg_rst_pin,
  input  logic               cfg_pullup_en,
  input  logic [P_WIDTH-1:0] cfg_alt_mask,
  input  logic               chg_en,
  input  logic               chg_clr,
  input  logic [P_WIDTH-1:0] pin_in,
  output logic [P_WIDTH-1:0] pin_out,
  output logic [P_WIDTH-1:0] pin_oe,
  output logic [P_WIDTH-1:0] pin_pullup,
  output logic [P_WIDTH-1:0] port_rdata,
  output logic [P_WIDTH-1:0] dir_rdata,
  output logic               chg_flag,
  output logic               chg_irq
);
  import gpio_pkg::*;
  localparam logic [P_WIDTH-1:0] SOLO = P_WIDTH'(bit_mask(P_SOLO_BIT));

  logic [P_WIDTH-1:0] pins_sync;
  logic [P_WIDTH-1:0] read_view;
  logic [P_WIDTH-1:0] latch_q;
  logic [P_WIDTH-1:0] dir_q;

  gpio_sync #(.W(P_WIDTH), .STAGES(P_SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  assign read_view = pins_sync & ~cfg_alt_mask & ~(cfg_rst_pin ? SOLO : '0);

  gpio_regs #(.W(P_WIDTH), .SOLO_BIT(P_SOLO_BIT), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst(rst), .wdata(wdata), .port_wr(port_wr), .dir_wr(dir_wr),
    .rmw_en(rmw_en), .rmw_bit(rmw_bit), .rmw_val(rmw_val),
    .read_view(read_view), .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_chg #(.W(P_WIDTH), .SOLO_BIT(P_SOLO_BIT), .WATCH(P_CHG_MASK)) u_chg (
    .clk(clk), .rst(rst), .pins_sync(pins_sync), .port_rd(port_rd),
    .solo_is_rst(cfg_rst_pin), .chg_clr(chg_clr), .flag_q(chg_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) port_rdata <= '0;
    else     port_rdata <= read_view;
  end

  assign pin_out    = latch_q;
  assign pin_oe     = ~dir_q & ~SOLO;
  assign dir_rdata  = dir_q | SOLO;
  assign pin_pullup = (cfg_pullup_en ? P_CHG_MASK : '0) | (cfg_rst_pin ? SOLO : '0);
  assign chg_irq    = chg_flag & chg_en;

  assert_alt_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (port_rdata & $past(cfg_alt_mask)) == '0);
endmodule

// File: tb/test_gpio_port_block.sv
module test_gpio_port_block;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] wdata;
  logic       port_wr, port_rd, dir_wr, rmw_en, rmw_val;
  logic [2:0] rmw_bit;
  logic       cfg_rst_pin, cfg_pullup_en;
  logic [5:0] cfg_alt_mask;
  logic       chg_en, chg_clr;
  logic [5:0] pin_in;
  logic [5:0] pin_out, pin_oe, pin_pullup, port_rdata, dir_rdata;
  logic       chg_flag, chg_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_block i_gpio_port_block (
    .clk(clk), .rst(rst), .wdata(wdata), .port_wr(port_wr), .port_rd(port_rd),
    .dir_wr(dir_wr), .rmw_en(rmw_en), .rmw_bit(rmw_bit), .rmw_val(rmw_val),
    .cfg_rst_pin(cfg_rst_pin), .cfg_pullup_en(cfg_pullup_en),
    .cfg_alt_mask(cfg_alt_mask), .chg_en(chg_en), .chg_clr(chg_clr),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .port_rdata(port_rdata), .dir_rdata(dir_rdata), .chg_flag(chg_flag),
    .chg_irq(chg_irq)
  );

  // pin, alt mask, reset-pin mode, expected read
  localparam logic [18:0] VEC [6] = '{
    {6'h3F, 6'h00, 1'b0, 6'h3F},
    {6'h15, 6'h00, 1'b0, 6'h15},
    {6'h2A, 6'h00, 1'b1, 6'h22},
    {6'h3F, 6'h06, 1'b0, 6'h39},
    {6'h3F, 6'h30, 1'b1, 6'h07},
    {6'h00, 6'h3F, 1'b0, 6'h00}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic resync;
    port_rd = 1'b1; cyc(1); port_rd = 1'b0;
    chg_clr = 1'b1; cyc(1); chg_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wdata = '0; port_wr = 0; port_rd = 0; dir_wr = 0; rmw_en = 0;
    rmw_val = 0; rmw_bit = '0; cfg_rst_pin = 0; cfg_pullup_en = 0;
    cfg_alt_mask = '0; chg_en = 0; chg_clr = 0; pin_in = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1 dir", dir_rdata, 6'h3F);
    check("R1 oe", pin_oe, 6'h00);
    check("R1 out", pin_out, 6'h00);
    check("R1 flag", {5'b0, chg_flag}, 6'h00);

    // R2/R4/R5 table walk
    foreach (VEC[k]) begin
      pin_in = VEC[k][18:13]; cfg_alt_mask = VEC[k][12:7]; cfg_rst_pin = VEC[k][6];
      cyc(3);
      check("R2/R4/R5 read view", port_rdata, VEC[k][5:0]);
    end
    cfg_alt_mask = '0; cfg_rst_pin = 0; pin_in = '0;
    cyc(3); resync;
    check("R9 cleared", {5'b0, chg_flag}, 6'h00);

    // R11 / R3 direction and drive
    wdata = 6'h00; dir_wr = 1; cyc(1); dir_wr = 0;
    check("R3 dir bit3", dir_rdata, 6'h08);
    check("R11 oe", pin_oe, 6'h37);
    wdata = 6'h3F; port_wr = 1; cyc(1); port_wr = 0;
    check("R3 out bit3", pin_out, 6'h37);
    cyc(3);
    check("R2 reads pins not latch", port_rdata, 6'h00);
    // write beats rmw in the same cycle
    wdata = 6'h00; port_wr = 1; rmw_en = 1; rmw_bit = 3'd1; rmw_val = 1;
    cyc(1); port_wr = 0; rmw_en = 0;
    check("R6 write wins", pin_out, 6'h00);

    // R6 read-modify-write
    wdata = 6'h3F; dir_wr = 1; cyc(1); dir_wr = 0;
    pin_in = 6'h05; cyc(3);
    rmw_en = 1; rmw_bit = 3'd4; rmw_val = 1; cyc(1); rmw_en = 0;
    check("R6 input bits copied", pin_out, 6'h15);
    wdata = 6'h00; dir_wr = 1; cyc(1); dir_wr = 0;
    rmw_en = 1; rmw_bit = 3'd0; rmw_val = 0; cyc(1); rmw_en = 0;
    check("R6 output bit from pin", pin_out, 6'h04);

    // R7 / R5 pull-ups
    cfg_pullup_en = 1; cyc(1);
    check("R7 pullup group", pin_pullup, 6'h0B);
    cfg_pullup_en = 0; cfg_rst_pin = 1; cyc(1);
    check("R5 pullup forced", pin_pullup, 6'h08);
    cfg_rst_pin = 0; cyc(1);
    check("R7 pullup off", pin_pullup, 6'h00);

    // R8 change detection
    resync;
    pin_in = 6'h01; cyc(4);
    check("R8 unwatched pin", {5'b0, chg_flag}, 6'h00);
    resync;
    pin_in = 6'h03; cyc(2);
    check("R8 before sync", {5'b0, chg_flag}, 6'h00);
    cyc(1);
    check("R8 flag without enable", {5'b0, chg_flag}, 6'h01);
    check("R10 irq gated", {5'b0, chg_irq}, 6'h00);
    chg_en = 1; cyc(1);
    check("R10 irq on", {5'b0, chg_irq}, 6'h01);
    port_rd = 1; cyc(1); port_rd = 0; cyc(4);
    check("R9 sticky", {5'b0, chg_flag}, 6'h01);
    chg_clr = 1; cyc(1); chg_clr = 0;
    check("R9 clear", {5'b0, chg_flag}, 6'h00);
    check("R10 irq off", {5'b0, chg_irq}, 6'h00);

    // R5 reset-pin mode on bit 3
    cfg_rst_pin = 1; pin_in = 6'h0B; cyc(4);
    check("R5 no change irq", {5'b0, chg_flag}, 6'h00);
    check("R5 reads zero", port_rdata, 6'h03);
    cfg_rst_pin = 0; cyc(3); resync;

    // R9 set and clear on the same edge
    pin_in = 6'h0A; cyc(2);
    chg_clr = 1; cyc(1); chg_clr = 0;
    check("R9 set beats clear", {5'b0, chg_flag}, 6'h01);
    resync;
    check("R9 clear after read", {5'b0, chg_flag}, 6'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule